// File: doc/BRIEF.md
# Host-to-Slave Byte Mailbox with Buffer Status Flags

This block is a byte-wide mailbox between an external host bus and an internal slave processor bus. It has one or two channels, set by a parameter. Each channel holds four pieces of state:
- an inbound byte, which the host writes and the slave reads;
- an outbound byte, which the slave writes and the host reads;
- two handshake flags that say which buffer holds unread data;
- a command/data marker that records the host address bit of the last host write.

The host interface is asynchronous. It has one active-low chip select per channel, a shared address bit, and active-low read and write strobes. These signals pass through two-flop synchronizers into the slave clock. Strobe rising edges are detected there, and only then are the flags updated. The host must hold chip select, address and write data stable from before a strobe falls until at least three slave clocks after it rises. Host read data is a combinational mux and is valid while the read strobe is low.

The slave side is a single-cycle synchronous register bus. An access with `sl_we` low is a read. The slave gets one level interrupt per channel. It is high while that channel's inbound byte is unread.

Top module: `host_mailbox`

## Requirements
- R1: After reset, every channel's status byte reads 0x00 and every interrupt output is 0.
- R2: A host write with channel g's chip select low loads `host_wdata` into channel g's inbound byte. The effect is visible from the third slave clock edge after the write strobe rises. The slave reads the inbound byte at slave address {g, 0}.
- R3: The same host write copies `host_addr` into the status command/data bit (bit 3): 1 marks a command and 0 marks data.
- R4: The same host write sets the inbound-full flag (status bit 1). Each interrupt output equals its channel's inbound-full flag.
- R5: A slave read at address {g, 0} clears channel g's inbound-full flag at the clock edge that ends the read cycle. A slave read of the status address {g, 1} leaves the flag unchanged.
- R6: A slave write at address {g, 0} loads the outbound byte and sets the outbound-full flag (status bit 0) at that clock edge. A host read with `host_addr` low returns the outbound byte, and a host read with `host_addr` high returns the status byte. Status bit 2 and bits 7 to 4 read 0.
- R7: A host read with `host_addr` low clears the outbound-full flag at the third slave clock edge after the read strobe rises. A host read of the status byte leaves the flag unchanged.
- R8: If a flag's set event and clear event fall in the same slave clock cycle, the set wins. This holds for a host write against a slave inbound read, and for a slave outbound write against a host outbound read.
- R9: Host strobes while every chip select is high change nothing. A slave write to a status address changes nothing.
- R10: Channels are independent. An access to one channel leaves the other channel's bytes and flags unchanged. When both chip selects are low on a host read, channel 0 is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | NUM_CH | Per-channel host chip select, active low |
| host_addr | input | 1 | Host address bit: 1 selects command/status, 0 selects data |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, 0 when no read is in progress |
| sl_en | input | 1 | Slave access valid for this cycle |
| sl_we | input | 1 | Slave write (1) or read (0) |
| sl_addr | input | SAW | Slave address: upper bits pick the channel, bit 0 picks data (0) or status (1) |
| sl_wdata | input | DW | Slave write data |
| sl_rdata | output | DW | Slave read data for the current address |
| sl_irq | output | NUM_CH | Per-channel inbound-full interrupt |

## Verification
The hardest case to reach is the collision in R8. A synchronized host strobe edge must commit in exactly the slave clock cycle that a slave access touches the same flag, and the synchronizer delay hides that cycle from the ports. The bench counts edges from the moment it raises the host strobe. It then places a slave inbound read, or a slave outbound write, in the commit cycle and checks that the flag stays set and that the new byte is kept. Around these directed cases, seeded random host and slave operations on both channels run against a bench model of the bytes and flags.

// File: rtl/hmbx_pkg.sv
// Package: shared constants and helpers for the host mailbox.
// Assumes: data width is at least 4 bits so the status byte fits.
package hmbx_pkg;

    // Status bit positions; host and slave software decode these.
    localparam int STAT_OBF_BIT = 0;
    localparam int STAT_IBF_BIT = 1;
    localparam int STAT_CD_BIT  = 3;

    // Slave register select carried in slave address bit 0.
    localparam logic SREG_DATA = 1'b0;
    localparam logic SREG_STAT = 1'b1;

    // Build an 8-bit status image from the three flags.
    function automatic logic [7:0] pack_status(input logic obf, input logic ibf, input logic cd);
        logic [7:0] s;
        s = 8'h00;
        s[STAT_OBF_BIT] = obf;
        s[STAT_IBF_BIT] = ibf;
        s[STAT_CD_BIT]  = cd;
        return s;
    endfunction

endpackage

// File: rtl/hmbx_sync.sv
// Module: multi-bit, multi-stage synchronizer into the slave clock.
// Assumes: each bit is an independent level; bits may land one cycle apart.
module hmbx_sync #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    // First stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    // Remaining stages form the resolution chain.
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[k] <= RST_VAL;
            else        stg[k] <= stg[k-1];
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/hmbx_hostfe.sv
// Module: host front end. Synchronizes the host strobes, chip selects and
// address bit, then turns each strobe's rising edge into a one-cycle commit pulse per channel.
// Assumes: chip select and address are stable while a strobe is low and for
// the synchronizer delay after it rises; strobes are never low together.
module hmbx_hostfe #(
    parameter int NUM_CH = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] host_cs_n,
    input  logic              host_addr,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    output logic [NUM_CH-1:0] wr_commit,
    output logic [NUM_CH-1:0] rd_commit,
    output logic              addr_held
);

    localparam int SW = NUM_CH + 3;

    logic [SW-1:0]     raw_v, syn_v;
    logic              wr_s, rd_s, addr_s;
    logic [NUM_CH-1:0] cs_s, cs_held;
    logic              wr_p, rd_p;
    logic              wr_rise, rd_rise;

    assign raw_v = {host_cs_n, host_addr, host_rd_n, host_wr_n};

    hmbx_sync #(.W(SW), .STAGES(STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_v),
        .q_sync  (syn_v)
    );

    assign wr_s   = syn_v[0];
    assign rd_s   = syn_v[1];
    assign addr_s = syn_v[2];
    assign cs_s   = syn_v[SW-1:3];

    // Delayed strobe copies for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_p <= 1'b1;
            rd_p <= 1'b1;
        end else begin
            wr_p <= wr_s;
            rd_p <= rd_s;
        end
    end

    // Hold select and address from the low phase of a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_held   <= '1;
            addr_held <= 1'b0;
        end else if (!wr_s || !rd_s) begin
            cs_held   <= cs_s;
            addr_held <= addr_s;
        end
    end

    assign wr_rise = wr_s & ~wr_p;
    assign rd_rise = rd_s & ~rd_p;

    // Per-channel commit pulses qualified by the held chip select.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_commit
        assign wr_commit[g] = wr_rise & ~cs_held[g];
        assign rd_commit[g] = rd_rise & ~cs_held[g];
    end

    // A detected edge lasts exactly one slave cycle (feeds R4 and R7).
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rise |=> !wr_rise);
    assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |=> !rd_rise);

endmodule

// File: rtl/hmbx_chan.sv
// Module: one mailbox channel. Holds the inbound and outbound bytes, the
// full flags and the command/data marker; drives the channel interrupt.
// Assumes: host commit pulses are one slave cycle long; slave strobes are
// already decoded to this channel's data register.
module hmbx_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_wr_commit,
    input  logic          h_rd_commit,
    input  logic          h_addr,
    input  logic [DW-1:0] h_wdata,
    input  logic          s_rd_data,
    input  logic          s_wr_data,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] idr,
    output logic [DW-1:0] odr,
    output logic [DW-1:0] status,
    output logic          irq
);

    import hmbx_pkg::*;

    logic ibf, obf, cd;
    logic obf_clr;

    // Only a host read of the data byte drains the outbound buffer.
    assign obf_clr = h_rd_commit & ~h_addr;

    // Inbound byte: loaded by host writes, no reset value.
    always_ff @(posedge clk) begin
        if (h_wr_commit) idr <= h_wdata;
    end

    // Outbound byte: loaded by slave writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         odr <= '0;
        else if (s_wr_data) odr <= s_wdata;
    end

    // Inbound-full flag: the set takes priority over the slave clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           ibf <= 1'b0;
        else if (h_wr_commit) ibf <= 1'b1;
        else if (s_rd_data)   ibf <= 1'b0;
    end

    // Outbound-full flag: the set takes priority over the host clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         obf <= 1'b0;
        else if (s_wr_data) obf <= 1'b1;
        else if (obf_clr)   obf <= 1'b0;
    end

    // Command/data marker follows the address of each host write.
    always_ff @(posedge clk) begin
        if (!rst_n)           cd <= 1'b0;
        else if (h_wr_commit) cd <= h_addr;
    end

    assign status = DW'(pack_status(obf, ibf, cd));
    assign irq    = ibf;

    assert_ibf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr_commit |=> ibf);
    assert_cd_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr_commit |=> (cd == $past(h_addr)));
    assert_ibf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd_data && !h_wr_commit) |=> !ibf);
    assert_ibf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_rd_data && !h_wr_commit) |=> $stable(ibf));
    assert_obf_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_wr_data |=> (obf && odr == $past(s_wdata)));
    assert_obf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (obf_clr && !s_wr_data) |=> !obf);
    assert_obf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!obf_clr && !s_wr_data) |=> $stable(obf));

endmodule

// File: rtl/hmbx_hrdmux.sv
// Module: host read-data mux. Returns the selected channel's status byte
// (address bit high) or outbound byte (address bit low) while the read strobe is low.
// Assumes: the lowest-numbered selected channel wins if several are selected.
module hmbx_hrdmux #(
    parameter int NUM_CH = 2,
    parameter int DW     = 8
) (
    input  logic [NUM_CH-1:0]         host_cs_n,
    input  logic                      host_addr,
    input  logic                      host_rd_n,
    input  logic [NUM_CH-1:0][DW-1:0] odr_a,
    input  logic [NUM_CH-1:0][DW-1:0] stat_a,
    output logic [DW-1:0]             host_rdata
);

    // Scan from the top so the lowest selected channel is kept.
    always_comb begin
        host_rdata = '0;
        if (!host_rd_n) begin
            for (int i = NUM_CH - 1; i >= 0; i--) begin
                if (!host_cs_n[i]) host_rdata = host_addr ? stat_a[i] : odr_a[i];
            end
        end
    end

endmodule

// File: rtl/host_mailbox.sv
// Module: host/slave byte mailbox top. Joins the host front end, the
// per-channel registers, the host read mux and the slave register decode.
// Assumes: NUM_CH is 1 or 2; the slave bus is single-cycle and reads are combinational.
module host_mailbox #(
    parameter int NUM_CH = 2,
    parameter int DW     = 8,
    parameter int STAGES = 2,
    localparam int SAW   = $clog2(NUM_CH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] host_cs_n,
    input  logic              host_addr,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    input  logic              sl_en,
    input  logic              sl_we,
    input  logic [SAW-1:0]    sl_addr,
    input  logic [DW-1:0]     sl_wdata,
    output logic [DW-1:0]     sl_rdata,
    output logic [NUM_CH-1:0] sl_irq
);

    import hmbx_pkg::*;

    logic [NUM_CH-1:0]         wr_commit, rd_commit;
    logic                      addr_held;
    logic [NUM_CH-1:0][DW-1:0] idr_a, odr_a, stat_a;
    logic [NUM_CH-1:0]         s_rd_data, s_wr_data;
    logic [SAW-1:0]            ch_field;

    hmbx_hostfe #(.NUM_CH(NUM_CH), .STAGES(STAGES)) u_fe (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_cs_n (host_cs_n),
        .host_addr (host_addr),
        .host_rd_n (host_rd_n),
        .host_wr_n (host_wr_n),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .addr_held (addr_held)
    );

    assign ch_field = sl_addr >> 1;

    // One channel instance per mailbox, each with its own slave decode.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign s_rd_data[g] = sl_en & ~sl_we & (sl_addr[0] == SREG_DATA) & (ch_field == SAW'(g));
        assign s_wr_data[g] = sl_en &  sl_we & (sl_addr[0] == SREG_DATA) & (ch_field == SAW'(g));

        hmbx_chan #(.DW(DW)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .h_wr_commit (wr_commit[g]),
            .h_rd_commit (rd_commit[g]),
            .h_addr      (addr_held),
            .h_wdata     (host_wdata),
            .s_rd_data   (s_rd_data[g]),
            .s_wr_data   (s_wr_data[g]),
            .s_wdata     (sl_wdata),
            .idr         (idr_a[g]),
            .odr         (odr_a[g]),
            .status      (stat_a[g]),
            .irq         (sl_irq[g])
        );
    end

    hmbx_hrdmux #(.NUM_CH(NUM_CH), .DW(DW)) u_hrd (
        .host_cs_n  (host_cs_n),
        .host_addr  (host_addr),
        .host_rd_n  (host_rd_n),
        .odr_a      (odr_a),
        .stat_a     (stat_a),
        .host_rdata (host_rdata)
    );

    // Slave read data: the inbound byte or the status of the addressed channel.
    always_comb begin
        sl_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_field == SAW'(i)) sl_rdata = (sl_addr[0] == SREG_STAT) ? stat_a[i] : idr_a[i];
        end
    end

    // At most one channel is decoded per slave access (R10).
    assert_one_slave_ch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_rd_data | s_wr_data));
    // Interrupts are low in the first cycle after reset (R1).
    assert_irq_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (sl_irq == '0));

endmodule

// File: tb/test_host_mailbox.sv
// Bench: directed corner cases plus seeded random host/slave traffic,
// checked against a bench model of the bytes and flags.
module test_host_mailbox;

    localparam int NUM_CH = 2;
    localparam int DW     = 8;
    localparam int SAW    = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NUM_CH-1:0] host_cs_n;
    logic              host_addr, host_rd_n, host_wr_n;
    logic [DW-1:0]     host_wdata, host_rdata;
    logic              sl_en, sl_we;
    logic [SAW-1:0]    sl_addr;
    logic [DW-1:0]     sl_wdata, sl_rdata;
    logic [NUM_CH-1:0] sl_irq;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model.
    logic [DW-1:0] m_idr [NUM_CH];
    logic [DW-1:0] m_odr [NUM_CH];
    logic          m_ibf [NUM_CH];
    logic          m_obf [NUM_CH];
    logic          m_cd  [NUM_CH];
    logic          m_idr_ok [NUM_CH];

    always #10 clk = ~clk;

    host_mailbox #(.NUM_CH(NUM_CH), .DW(DW)) i_host_mailbox (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_addr(host_addr),
        .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .sl_en(sl_en), .sl_we(sl_we), .sl_addr(sl_addr),
        .sl_wdata(sl_wdata), .sl_rdata(sl_rdata), .sl_irq(sl_irq)
    );

    // Expected status byte: bit 0 outbound-full, bit 1 inbound-full, bit 3 command.
    function automatic logic [7:0] exp_status(input int ch);
        return {4'b0, m_cd[ch], 1'b0, m_ibf[ch], m_obf[ch]};
    endfunction

    function automatic logic [NUM_CH-1:0] exp_irq();
        logic [NUM_CH-1:0] v;
        for (int i = 0; i < NUM_CH; i++) v[i] = m_ibf[i];
        return v;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Host write: strobe low four cycles, then high; commit lands during the wait.
    task automatic host_write(input int ch, input logic a, input logic [7:0] d, input bit sel);
        @(negedge clk);
        host_cs_n = '1;
        if (sel) host_cs_n[ch] = 1'b0;
        host_addr = a; host_wdata = d; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = '1;
        if (sel) begin
            m_idr[ch] = d; m_idr_ok[ch] = 1'b1; m_ibf[ch] = 1'b1; m_cd[ch] = a;
        end
    endtask

    task automatic host_read(input int ch, input logic a, input string req);
        @(negedge clk);
        host_cs_n = '1; host_cs_n[ch] = 1'b0;
        host_addr = a; host_rd_n = 1'b0;
        #1;
        chk(req, host_rdata, a ? exp_status(ch) : m_odr[ch]);
        repeat (3) @(negedge clk);
        host_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        host_cs_n = '1;
        if (!a) m_obf[ch] = 1'b0;
    endtask

    task automatic slave_read(input int ch, input logic reg_sel, input string req);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b0; sl_addr = {ch[0], reg_sel};
        #1;
        if (reg_sel) chk(req, sl_rdata, exp_status(ch));
        else if (m_idr_ok[ch]) chk(req, sl_rdata, m_idr[ch]);
        @(negedge clk);
        sl_en = 1'b0;
        if (!reg_sel) m_ibf[ch] = 1'b0;
    endtask

    task automatic slave_write(input int ch, input logic reg_sel, input logic [7:0] d);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b1; sl_addr = {ch[0], reg_sel}; sl_wdata = d;
        @(negedge clk);
        sl_en = 1'b0; sl_we = 1'b0;
        if (!reg_sel) begin m_odr[ch] = d; m_obf[ch] = 1'b1; end
    endtask

    task automatic check_all(input string req);
        #1;
        chk(req, 8'(sl_irq), 8'(exp_irq()));
        for (int c = 0; c < NUM_CH; c++) slave_read(c, 1'b1, req);
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        #3000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        host_cs_n = '1; host_addr = 1'b0; host_rd_n = 1'b1; host_wr_n = 1'b1;
        host_wdata = '0; sl_en = 1'b0; sl_we = 1'b0; sl_addr = '0; sl_wdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            m_idr[c] = '0; m_odr[c] = '0; m_ibf[c] = 0; m_obf[c] = 0; m_cd[c] = 0; m_idr_ok[c] = 0;
        end
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check_all("R1");

        // R2/R3/R4: data write, then command write, on channel 0.
        host_write(0, 1'b0, 8'h5A, 1);
        check_all("R4");
        slave_read(0, 1'b0, "R2");
        check_all("R5");
        host_write(0, 1'b1, 8'hC3, 1);
        check_all("R3");
        slave_read(0, 1'b1, "R5 status read keeps flag");
        check_all("R5");
        slave_read(0, 1'b0, "R2");

        // R6/R7: outbound path; status read does not drain.
        slave_write(1, 1'b0, 8'h96);
        check_all("R6");
        host_read(1, 1'b1, "R6");
        check_all("R7 status read keeps flag");
        host_read(1, 1'b0, "R6");
        check_all("R7");

        // R9: unselected host write and slave status write are ignored.
        host_write(0, 1'b1, 8'hEE, 0);
        check_all("R9");
        slave_write(0, 1'b1, 8'hFF);
        check_all("R9");
        host_read(0, 1'b0, "R9");

        // R10: both selects low returns channel 0.
        slave_write(0, 1'b0, 8'h11);
        slave_write(1, 1'b0, 8'h22);
        @(negedge clk);
        host_cs_n = '0; host_addr = 1'b0; host_rd_n = 1'b0;
        #1 chk("R10", host_rdata, 8'h11);
        @(negedge clk);
        host_rd_n = 1'b1; host_cs_n = '1;
        repeat (5) @(negedge clk);
        m_obf[0] = 1'b0; m_obf[1] = 1'b0;
        check_all("R10");

        // R8: host write commit collides with a slave inbound read.
        @(negedge clk);
        host_cs_n = 2'b10; host_addr = 1'b0; host_wdata = 8'h77; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b0; sl_addr = 2'b00;
        @(negedge clk);
        sl_en = 1'b0;
        repeat (3) @(negedge clk);
        host_cs_n = '1;
        m_idr[0] = 8'h77; m_ibf[0] = 1'b1; m_cd[0] = 1'b0;
        check_all("R8");
        slave_read(0, 1'b0, "R8");

        // R8: host outbound read commit collides with a slave write.
        slave_write(1, 1'b0, 8'h3C);
        @(negedge clk);
        host_cs_n = 2'b01; host_addr = 1'b0; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        host_rd_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sl_en = 1'b1; sl_we = 1'b1; sl_addr = 2'b10; sl_wdata = 8'hA5;
        @(negedge clk);
        sl_en = 1'b0; sl_we = 1'b0;
        repeat (3) @(negedge clk);
        host_cs_n = '1;
        m_odr[1] = 8'hA5; m_obf[1] = 1'b1;
        check_all("R8");
        host_read(1, 1'b0, "R8");

        // Random traffic over both channels.
        for (int n = 0; n < 250; n++) begin
            int op, ch;
            op = int'($urandom_range(3, 0));
            ch = int'($urandom_range(1, 0));
            case (op)
                0: host_write(ch, 1'($urandom_range(1, 0)), 8'($urandom), 1);
                1: host_read(ch, 1'($urandom_range(1, 0)), "R7 random");
                2: slave_read(ch, 1'($urandom_range(1, 0)), "R5 random");
                default: slave_write(ch, 1'($urandom_range(1, 0)), 8'($urandom));
            endcase
            if (n % 10 == 0) check_all("R10 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule